// File: doc/BRIEF.md
# DMA Channel Transfer-Request Generator

This block drives the request side of a single DMA channel. Once the channel is started it asks the bus arbiter for the bus, one transfer unit at a time. It counts down the bytes left to move and reports completion when the count runs out. The request can come from one of two sources. The internal source keeps requesting without a break. The external source follows an asynchronous device request line (DREQ), which the block synchronises first. That line can be detected on an edge or on a level, with either polarity.

The unit size is a 2-bit code that is latched at start. The code gives both the `size_o` output and the amount subtracted from the byte counter for each finished unit. A stop request always waits for the unit in flight to finish. Address generation, the bus cycle itself, arbitration between channels and register decoding all sit outside this block.

Top module: `dma_req_gen`

## Requirements
- R1: After reset `req_o` is 0, `remaining_o` is 0 and `done_o` is 0, and the channel is idle.
- R2: With `ext_sel_i`=0, a `start_i` accepted at a clock edge makes `req_o` high right after that edge. The request stays high across back-to-back units until the byte count is exhausted.
- R3: Size code 00 moves 4 bytes, 01 moves 2 bytes and 10 moves 1 byte per unit. Code 11 is reserved: a start with it, or with `len_i`=0, is ignored. `size_o` holds the code latched at start, and later changes of `size_i` have no effect on it. Each finished unit subtracts the step from `remaining_o`. A count smaller than the step saturates to 0 and never wraps.
- R4: When the last unit finishes, `remaining_o` becomes 0, `req_o` drops and `done_o` is high for exactly one cycle. No further request appears until `start_i` is given again.
- R5: With `ext_sel_i`=1, DREQ activity before the start is ignored, including a line that was already held active. In edge mode only an active edge seen after the start raises a request.
- R6: In edge mode each active edge yields exactly one unit. A second unit needs DREQ to go inactive and then make a new active edge.
- R7: In level mode, DREQ held at its active level yields consecutive units with no deassertion needed.
- R8: With `active_high_i`=0 the active edge is falling and the active level is low. With `active_high_i`=1 they are rising and high.
- R9: A stop while the channel waits for DREQ returns it to idle at once. A stop during a unit lets that unit finish and decrement the counter, with no `done_o` pulse. After that no new unit starts, even with DREQ held active.
- R10: `req_o` stays high until a cycle with both `grant_i` and `unit_done_i`. A `unit_done_i` while no request is up leaves the counter unchanged.
- R11: An active DREQ edge applied between clock edges shows up as `req_o` high after the third following clock edge. Two stages of that delay come from the synchronizer and one from the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for the channel |
| stop_i | input | 1 | Stop strobe for the channel |
| ext_sel_i | input | 1 | 1 = follow DREQ, 0 = internal continuous request |
| level_mode_i | input | 1 | 1 = level detection, 0 = edge detection |
| active_high_i | input | 1 | 1 = rising/high active, 0 = falling/low active |
| size_i | input | 2 | Unit size code (00 word, 01 half, 10 byte, 11 reserved) |
| len_i | input | CNT_W | Byte count loaded at start |
| dreq_i | input | 1 | Asynchronous device request |
| grant_i | input | 1 | Bus granted to this channel |
| unit_done_i | input | 1 | Datapath finished one unit |
| req_o | output | 1 | Request to the bus arbiter |
| size_o | output | 2 | Latched size code of the running transfer |
| remaining_o | output | CNT_W | Bytes still to move |
| done_o | output | 1 | One-cycle channel completion pulse |

## Verification
Start and unit completion act after one edge. A start taken at an edge shows `req_o`, `remaining_o` and `size_o` right after that edge, and a unit finished at an edge updates the counter, `req_o` and `done_o` at that same edge. A DREQ change needs three edges to reach `req_o`. The bench drives inputs just after a falling edge and samples just before the next one, so every result is checked in the cycle where it first becomes due. A reference model in the bench repeats the size, step and saturation rules edge by edge during random runs.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WAIT = 2'd1, ST_XFER = 2'd2} chan_state_e;

  localparam logic [1:0] SZ_WORD = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_BYTE = 2'b10;
  localparam logic [1:0] SZ_RSVD = 2'b11;

  function automatic logic [2:0] size_step(input logic [1:0] code);
    case (code)
      SZ_WORD: size_step = 3'd4;
      SZ_HALF: size_step = 3'd2;
      SZ_BYTE: size_step = 3'd1;
      default: size_step = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/dma_dreq_detect.sv
module dma_dreq_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dreq_i,
  input  logic active_high_i,
  input  logic level_mode_i,
  input  logic arm_i,
  input  logic consume_i,
  output logic trig_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic edge_pend_q;
  logic act_now, act_prev, edge_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], dreq_i};
      prev_q <= sync_q[MSB];
    end
  end

  // polarity applied to both samples, so a polarity change makes no edge
  assign act_now  = active_high_i ? sync_q[MSB] : ~sync_q[MSB];
  assign act_prev = active_high_i ? prev_q : ~prev_q;
  assign edge_now = act_now & ~act_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      edge_pend_q <= 1'b0;
    else if (!arm_i || level_mode_i)  edge_pend_q <= 1'b0;
    else if (consume_i)               edge_pend_q <= 1'b0;
    else if (edge_now)                edge_pend_q <= 1'b1;
  end

  assign trig_o = level_mode_i ? act_now : (edge_pend_q | edge_now);

  p_no_pend_unarmed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> !edge_pend_q);
endmodule

// File: rtl/dma_byte_counter.sv
module dma_byte_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  input  logic [2:0]       step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] step_ext;

  assign step_ext = CNT_W'(step_i);
  assign last_o   = (cnt_q <= step_ext);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (dec_i)   cnt_q <= last_o ? '0 : cnt_q - step_ext;
  end

  assign cnt_o = cnt_q;

  p_no_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |=> (cnt_o <= $past(cnt_o)));
  p_hold_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_i && !load_i) |=> $stable(cnt_o));
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_req_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             ext_sel_i,
  input  logic             level_mode_i,
  input  logic             active_high_i,
  input  logic [1:0]       size_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             dreq_i,
  input  logic             grant_i,
  input  logic             unit_done_i,
  output logic             req_o,
  output logic [1:0]       size_o,
  output logic [CNT_W-1:0] remaining_o,
  output logic             done_o
);
  chan_state_e state_q, state_d;
  logic        ext_q;
  logic [1:0]  size_q;
  logic        stop_pend_q;
  logic        done_q;
  logic        start_ok, unit_fin, trig, last, consume, arm;

  assign start_ok = start_i && (size_i != SZ_RSVD) && (len_i != '0);
  assign unit_fin = (state_q == ST_XFER) && grant_i && unit_done_i;
  assign arm      = (state_q != ST_IDLE);
  assign consume  = (state_q == ST_WAIT) && trig && !stop_i;

  dma_dreq_detect #(.SYNC_STAGES(SYNC_STAGES)) i_detect (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dreq_i       (dreq_i),
    .active_high_i(active_high_i),
    .level_mode_i (level_mode_i),
    .arm_i        (arm),
    .consume_i    (consume),
    .trig_o       (trig)
  );

  dma_byte_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    ((state_q == ST_IDLE) && start_ok),
    .load_val_i(len_i),
    .dec_i     (unit_fin),
    .step_i    (size_step(size_q)),
    .cnt_o     (remaining_o),
    .last_o    (last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_ok) state_d = ext_sel_i ? ST_WAIT : ST_XFER;
      ST_WAIT: begin
        if (stop_i)    state_d = ST_IDLE;
        else if (trig) state_d = ST_XFER;
      end
      ST_XFER: begin
        if (unit_fin) begin
          if (last || stop_pend_q || stop_i) state_d = ST_IDLE;
          else                               state_d = ext_q ? ST_WAIT : ST_XFER;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      ext_q       <= 1'b0;
      size_q      <= SZ_WORD;
      stop_pend_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= unit_fin && last;
      if (state_q == ST_IDLE && start_ok) begin
        ext_q  <= ext_sel_i;
        size_q <= size_i;
      end
      // stop during a unit is deferred to the unit boundary
      if (state_d == ST_IDLE)                          stop_pend_q <= 1'b0;
      else if (state_q == ST_XFER && stop_i)           stop_pend_q <= 1'b1;
    end
  end

  assign req_o  = (state_q == ST_XFER);
  assign size_o = size_q;
  assign done_o = done_q;

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !(grant_i && unit_done_i)) |=> req_o);
  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!req_o && remaining_o == '0));
  p_reserved_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && size_i == SZ_RSVD) |=> !req_o);
  p_wait_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && stop_i) |=> !req_o);
  p_idle_stays_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> !req_o);
endmodule

// File: tb/test_dma_req_gen.sv
module test_dma_req_gen;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, stop_i = 0, ext_sel_i = 0, level_mode_i = 0, active_high_i = 1;
  logic [1:0] size_i = 2'b00;
  logic [CW-1:0] len_i = '0;
  logic dreq_i = 0, grant_i = 0, unit_done_i = 0;
  logic req_o, done_o;
  logic [1:0] size_o;
  logic [CW-1:0] remaining_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dma_req_gen #(.CNT_W(CW)) i_dma_req_gen (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .ext_sel_i(ext_sel_i), .level_mode_i(level_mode_i), .active_high_i(active_high_i),
    .size_i(size_i), .len_i(len_i), .dreq_i(dreq_i), .grant_i(grant_i),
    .unit_done_i(unit_done_i), .req_o(req_o), .size_o(size_o),
    .remaining_o(remaining_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input longint act, input longint exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_step(input logic [1:0] s);
    case (s)
      2'b00: return 4;
      2'b01: return 2;
      2'b10: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic pulse_start(input logic [1:0] sz, input int len);
    size_i = sz; len_i = CW'(len); start_i = 1;
    cyc(1);
    start_i = 0;
  endtask

  task automatic unit();
    grant_i = 1; unit_done_i = 1;
    cyc(1);
    grant_i = 0; unit_done_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int units, dones, rem, st, guard;
    bit ereq;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd4242);
    cyc(3);
    rst_ni = 1;
    cyc(1);
    // R1 reset state
    chk_eq("R1 req", req_o, 0);
    chk_eq("R1 remaining", remaining_o, 0);
    chk_eq("R1 done", done_o, 0);

    // R2/R3/R4/R10 internal source
    ext_sel_i = 0;
    pulse_start(2'b00, 8);
    chk_eq("R2 req at start", req_o, 1);
    chk_eq("R3 loaded count", remaining_o, 8);
    chk_eq("R3 size_o", size_o, 0);
    unit();
    chk_eq("R3 word step", remaining_o, 4);
    chk_eq("R2 back to back", req_o, 1);
    grant_i = 1; cyc(1); grant_i = 0;
    chk_eq("R10 grant without done", req_o, 1);
    chk_eq("R10 count held", remaining_o, 4);
    unit();
    chk_eq("R4 count zero", remaining_o, 0);
    chk_eq("R4 req dropped", req_o, 0);
    chk_eq("R4 done pulse", done_o, 1);
    cyc(1);
    chk_eq("R4 done one cycle", done_o, 0);
    cyc(3);
    chk_eq("R4 no restart", req_o, 0);

    // R3 reserved code, R10 stray unit_done
    pulse_start(2'b11, 8);
    cyc(2);
    chk_eq("R3 reserved no req", req_o, 0);
    chk_eq("R3 reserved no load", remaining_o, 0);
    grant_i = 1; unit_done_i = 1; cyc(2); grant_i = 0; unit_done_i = 0;
    chk_eq("R10 stray done ignored", remaining_o, 0);
    pulse_start(2'b10, 0);
    chk_eq("R3 zero length ignored", req_o, 0);

    // R3 byte step, size latched, saturation
    pulse_start(2'b10, 3);
    size_i = 2'b00;
    unit();
    chk_eq("R3 byte step", remaining_o, 2);
    chk_eq("R3 size latched", size_o, 2);
    unit(); unit();
    chk_eq("R4 byte run done", done_o, 1);
    pulse_start(2'b01, 5);
    unit(); chk_eq("R3 half step", remaining_o, 3);
    unit(); chk_eq("R3 half step 2", remaining_o, 1);
    unit(); chk_eq("R3 saturate", remaining_o, 0);
    chk_eq("R4 saturate done", done_o, 1);

    // R5/R6/R11 external edge mode, active high
    ext_sel_i = 1; level_mode_i = 0; active_high_i = 1; dreq_i = 1;
    cyc(4);
    pulse_start(2'b00, 8);
    cyc(5);
    chk_eq("R5 early dreq ignored", req_o, 0);
    dreq_i = 0; cyc(4);
    chk_eq("R5 no req on inactive", req_o, 0);
    dreq_i = 1; cyc(2);
    chk_eq("R11 not before third edge", req_o, 0);
    cyc(1);
    chk_eq("R11 req at third edge", req_o, 1);
    unit();
    chk_eq("R6 one unit per edge", remaining_o, 4);
    chk_eq("R6 req drops", req_o, 0);
    cyc(5);
    chk_eq("R6 held level no more units", req_o, 0);
    dreq_i = 0; cyc(3); dreq_i = 1; cyc(3);
    chk_eq("R6 new edge new unit", req_o, 1);
    unit();
    chk_eq("R4 edge run done", done_o, 1);

    // R8 falling edge polarity
    active_high_i = 0; dreq_i = 1; cyc(4);
    pulse_start(2'b10, 1);
    cyc(3);
    chk_eq("R8 inactive high no req", req_o, 0);
    dreq_i = 0; cyc(2);
    chk_eq("R8 not yet", req_o, 0);
    cyc(1);
    chk_eq("R8 falling edge req", req_o, 1);
    unit();
    chk_eq("R8 done", done_o, 1);
    dreq_i = 0; active_high_i = 1; cyc(4);

    // R7 level mode consecutive units
    level_mode_i = 1; dreq_i = 1; cyc(4);
    size_i = 2'b10; len_i = 3; start_i = 1; grant_i = 1; unit_done_i = 1;
    units = 0; dones = 0;
    for (int i = 0; i < 16; i++) begin
      cyc(1);
      start_i = 0;
      if (req_o) units++;
      if (done_o) dones++;
    end
    grant_i = 0; unit_done_i = 0;
    chk_eq("R7 level units", units, 3);
    chk_eq("R7 level done", dones, 1);

    // R9 stop during level-mode unit
    pulse_start(2'b10, 10);
    guard = 0;
    while (!req_o && guard < 8) begin cyc(1); guard++; end
    chk_eq("R7 level req", req_o, 1);
    stop_i = 1; cyc(1); stop_i = 0;
    chk_eq("R9 unit in flight kept", req_o, 1);
    chk_eq("R9 count before finish", remaining_o, 10);
    unit();
    chk_eq("R9 unit finished", remaining_o, 9);
    chk_eq("R9 req dropped", req_o, 0);
    chk_eq("R9 no done on stop", done_o, 0);
    cyc(5);
    chk_eq("R9 held level no restart", req_o, 0);

    // R9 stop while waiting, edge mode
    level_mode_i = 0; dreq_i = 0; cyc(4);
    pulse_start(2'b00, 8);
    stop_i = 1; cyc(1); stop_i = 0;
    dreq_i = 1; cyc(5);
    chk_eq("R9 stop in wait", req_o, 0);
    dreq_i = 0;

    // random internal runs against the bench model (R2 R3 R4)
    ext_sel_i = 0;
    for (int r = 0; r < 40; r++) begin
      logic [1:0] sz;
      sz = 2'($urandom_range(0, 2));
      rem = $urandom_range(1, 40);
      st = exp_step(sz);
      pulse_start(sz, rem);
      ereq = 1;
      chk_eq("R2 random req at start", req_o, 1);
      guard = 0;
      while (ereq && guard < 400) begin
        bit g, d, edone;
        g = 1'($urandom_range(0, 1));
        d = 1'($urandom_range(0, 1));
        grant_i = g; unit_done_i = d;
        cyc(1);
        edone = 0;
        if (g && d) begin
          if (rem <= st) begin rem = 0; ereq = 0; edone = 1; end
          else rem = rem - st;
        end
        chk_eq("R3 random remaining", remaining_o, rem);
        chk_eq("R2 random req", req_o, ereq);
        chk_eq("R4 random done", done_o, edone);
        chk_eq("R3 random size_o", size_o, sz);
        guard++;
      end
      grant_i = 0; unit_done_i = 0;
      cyc(1);
      chk_eq("R4 random done cleared", done_o, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule